// File: doc/BRIEF.md
# Watchdog Timer with Vector-Overlapped Service Address

This block is a watchdog for a small 8-bit microcontroller with a 16-bit address bus. A free-running prescaler divides the system clock into ticks. A timeout counter counts those ticks. If software lets the count reach the selected limit, the block raises a one-clock reset request for the system reset sequencer.

Software services the watchdog by writing to the topmost address, 0xFFFF. That address also holds the low byte of the reset vector. A write there restarts the timeout whatever the data, so the block has no write-data input. A read there returns the vector byte supplied on an input. A separate strobe from the CPU marks the reset-vector fetch cycle, and that strobe clears the prescaler.

Two static configuration inputs control the watchdog. One turns it off and holds all of its state at zero. The other picks the short or the long timeout. The block has no interrupt output: its only effect is the reset request.

Top module: `wdg_guard`

## Requirements
- R1: While `rst` is high, `rst_req` is 0 and the prescaler and counter are zero. The first timeout after reset is released therefore comes a full period later.
- R2: With `cfg_short`=0 and no service, `rst_req` rises 2^LONG_BITS − 2^PRE_BITS clock edges after a zero state. Counting then starts over from zero.
- R3: With `cfg_short`=1, the period is 2^SHORT_BITS − 2^PRE_BITS clock edges.
- R4: Each timeout holds `rst_req` high for exactly one clock.
- R5: A bus write (`bus_wr`=1) to address 0xFFFF clears the timeout counter but leaves the prescaler phase alone. A write to any other address has no effect on the timing.
- R6: A service write in the same cycle as the expiring tick wins. No request is raised, and a fresh period starts.
- R7: While `bus_rd`=1 and `bus_addr`=0xFFFF, `rd_hit`=1 and `rd_data`=`vec_lo`. Otherwise `rd_hit`=0 and `rd_data`=0.
- R8: `vec_fetch`=1 clears the prescaler to zero, and no tick is counted in that cycle.
- R9: While `cfg_off`=1, no request is raised and the prescaler and counter are held at zero. After `cfg_off` falls, a full period follows.
- R10: If the rate changes to short while the count already meets or passes the short limit, the request is raised at the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | CPU address |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_rd | input | 1 | Read strobe for the current cycle |
| vec_fetch | input | 1 | CPU is fetching the reset vector this cycle |
| vec_lo | input | 8 | Low byte of the reset vector |
| cfg_off | input | 1 | Watchdog disable (static configuration) |
| cfg_short | input | 1 | 1 selects the short timeout (static configuration) |
| rd_hit | output | 1 | The current read targets the service address |
| rd_data | output | 8 | Read data, valid when `rd_hit` is set |
| rst_req | output | 1 | One-clock reset request on timeout |

## Verification
The assertions assume that the bus strobes and the configuration inputs change only between clock edges, and that `vec_fetch` is a single-cycle strobe. They also assume that a request is judged only in the cycle after its cause. The stimulus drives every input just after a falling edge. It pulses the write and fetch strobes for one cycle at a time and toggles the configuration inputs rarely. A bench model of the prescaler and counter tracks every edge, so collisions between a service write or a fetch and the expiring tick are placed at chosen edges rather than left to chance.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 8;
    localparam logic [ADDR_W-1:0] SERVICE_ADDR = 16'hFFFF;

    typedef enum logic {
        RATE_LONG  = 1'b0,
        RATE_SHORT = 1'b1
    } rate_t;

    typedef struct packed {
        logic wr_hit;
        logic rd_hit;
    } bus_hit_t;

    // Ticks of 2^pre_bits cycles needed for a period of 2^to_bits - 2^pre_bits cycles.
    function automatic int unsigned tick_limit(int unsigned to_bits, int unsigned pre_bits);
        return (32'd1 << (to_bits - pre_bits)) - 32'd1;
    endfunction

endpackage

// File: rtl/wdg_bus_decode.sv
module wdg_bus_decode
    import wdg_pkg::*;
(
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] vec_lo,
    output bus_hit_t          hit,
    output logic [DATA_W-1:0] rd_data
);
    logic at_top;

    always_comb begin
        at_top     = (bus_addr == SERVICE_ADDR);
        hit.wr_hit = at_top && bus_wr;
        hit.rd_hit = at_top && bus_rd;
        rd_data    = hit.rd_hit ? vec_lo : '0;
    end
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int unsigned PRE_BITS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic clear,
    output logic tick
);
    logic [PRE_BITS-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || hold || clear) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign tick = !hold && !clear && (phase == {PRE_BITS{1'b1}});
endmodule

// File: rtl/wdg_timeout_counter.sv
module wdg_timeout_counter
    import wdg_pkg::*;
#(
    parameter int unsigned CNT_W     = 14,
    parameter int unsigned LIM_LONG  = 16383,
    parameter int unsigned LIM_SHORT = 511
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  hold,
    input  logic  restart,
    input  logic  tick,
    input  rate_t rate,
    output logic  expire
);
    localparam logic [CNT_W:0] LIMIT_L = (CNT_W+1)'(LIM_LONG);
    localparam logic [CNT_W:0] LIMIT_S = (CNT_W+1)'(LIM_SHORT);

    logic [CNT_W-1:0] count;
    logic [CNT_W:0]   count_inc;
    logic [CNT_W:0]   limit;

    always_comb begin
        count_inc = {1'b0, count} + 1'b1;
        limit     = (rate == RATE_SHORT) ? LIMIT_S : LIMIT_L;
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            count  <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (restart) begin
                count <= '0;
            end else if (tick) begin
                if (count_inc >= limit) begin
                    count  <= '0;
                    expire <= 1'b1;
                end else begin
                    count <= count_inc[CNT_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
    import wdg_pkg::*;
#(
    parameter int unsigned LONG_BITS  = 18,
    parameter int unsigned SHORT_BITS = 13,
    parameter int unsigned PRE_BITS   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              vec_fetch,
    input  logic [DATA_W-1:0] vec_lo,
    input  logic              cfg_off,
    input  logic              cfg_short,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_data,
    output logic              rst_req
);
    localparam int unsigned CNT_W     = LONG_BITS - PRE_BITS;
    localparam int unsigned LIM_LONG  = tick_limit(LONG_BITS, PRE_BITS);
    localparam int unsigned LIM_SHORT = tick_limit(SHORT_BITS, PRE_BITS);

    bus_hit_t hit;
    logic     tick;
    rate_t    rate;

    assign rate   = cfg_short ? RATE_SHORT : RATE_LONG;
    assign rd_hit = hit.rd_hit;

    wdg_bus_decode u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .vec_lo   (vec_lo),
        .hit      (hit),
        .rd_data  (rd_data)
    );

    wdg_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .hold  (cfg_off),
        .clear (vec_fetch),
        .tick  (tick)
    );

    wdg_timeout_counter #(
        .CNT_W     (CNT_W),
        .LIM_LONG  (LIM_LONG),
        .LIM_SHORT (LIM_SHORT)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .hold    (cfg_off),
        .restart (hit.wr_hit),
        .tick    (tick),
        .rate    (rate),
        .expire  (rst_req)
    );
endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic        vec_fetch,
    input logic [7:0]  vec_lo,
    input logic        cfg_off,
    input logic        rd_hit,
    input logic [7:0]  rd_data,
    input logic        rst_req
);
    AST_REQ_AFTER_RESET: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> !rst_req); // R1
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst) rst_req |=> !rst_req); // R4
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst) (bus_wr && bus_addr == 16'hFFFF) |=> !rst_req); // R6
    AST_FETCH_NO_TICK: assert property (@(posedge clk) disable iff (rst) vec_fetch |=> !rst_req); // R8
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst) cfg_off |=> !rst_req); // R9
    AST_READ_VECTOR: assert property (@(posedge clk) disable iff (rst) (bus_rd && bus_addr == 16'hFFFF) |-> (rd_hit && rd_data == vec_lo)); // R7
    AST_READ_MISS: assert property (@(posedge clk) disable iff (rst) !(bus_rd && bus_addr == 16'hFFFF) |-> (!rd_hit && rd_data == 8'h00)); // R7
endmodule

bind wdg_guard wdg_guard_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .vec_fetch (vec_fetch),
    .vec_lo    (vec_lo),
    .cfg_off   (cfg_off),
    .rd_hit    (rd_hit),
    .rd_data   (rd_data),
    .rst_req   (rst_req)
);

// File: tb/wdg_guard_test.sv
`timescale 1ns/1ps
module wdg_guard_test;
    localparam int LB = 10;
    localparam int SB = 7;
    localparam int PB = 4;
    localparam int T_LONG  = (1 << LB) - (1 << PB);
    localparam int T_SHORT = (1 << SB) - (1 << PB);
    localparam int L_LONG  = (1 << (LB - PB)) - 1;
    localparam int L_SHORT = (1 << (SB - PB)) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        vec_fetch = 1'b0;
    logic [7:0]  vec_lo = 8'h00;
    logic        cfg_off = 1'b0;
    logic        cfg_short = 1'b0;
    logic        rd_hit;
    logic [7:0]  rd_data;
    logic        rst_req;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    // bench model state
    int   m_pre = 0;
    int   m_cnt = 0;
    logic m_req = 1'b0;
    logic m_live = 1'b0;

    always #2 clk = ~clk;

    wdg_guard #(.LONG_BITS(LB), .SHORT_BITS(SB), .PRE_BITS(PB)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .vec_fetch(vec_fetch), .vec_lo(vec_lo), .cfg_off(cfg_off), .cfg_short(cfg_short),
        .rd_hit(rd_hit), .rd_data(rd_data), .rst_req(rst_req)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_rd_data(input logic rd, input logic [15:0] a, input logic [7:0] v);
        return (rd && a == 16'hFFFF) ? int'(v) : 0;
    endfunction

    // Reference model built from R1..R10.
    always @(posedge clk) begin
        int lim;
        logic tk;
        lim = cfg_short ? L_SHORT : L_LONG;
        tk  = !cfg_off && !vec_fetch && (m_pre == (1 << PB) - 1);
        if (rst || cfg_off) begin
            m_pre <= 0; m_cnt <= 0; m_req <= 1'b0;
        end else begin
            m_pre <= vec_fetch ? 0 : (m_pre + 1) % (1 << PB);
            m_req <= 1'b0;
            if (bus_wr && bus_addr == 16'hFFFF) m_cnt <= 0;
            else if (tk) begin
                if (m_cnt + 1 >= lim) begin m_cnt <= 0; m_req <= 1'b1; end
                else m_cnt <= m_cnt + 1;
            end
        end
        m_live <= !rst;
    end

    always @(negedge clk) begin
        if (m_live) check("R2 model rst_req", int'(rst_req), int'(m_req));
    end

    task automatic idle_bus();
        bus_wr = 1'b0; bus_rd = 1'b0; vec_fetch = 1'b0; bus_addr = 16'h0000;
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!rst_req && n < 5000);
    endtask

    task automatic skip(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        int seen;
        void'($urandom(32'h5eed1234));
        idle_bus();
        skip(5);
        check("R1 rst_req in reset", int'(rst_req), 0);
        rst = 1'b0;
        wait_pulse(n);
        check("R1 R2 first long period", n, T_LONG);
        @(negedge clk);
        check("R4 pulse width", int'(rst_req), 0);
        cfg_short = 1'b1;
        wait_pulse(n);
        check("R3 short period", n, T_SHORT - 1);

        // R5: foreign-address write ignored
        skip(49);
        bus_addr = 16'hFFFE; bus_wr = 1'b1;
        @(negedge clk); idle_bus();
        wait_pulse(n);
        check("R5 write elsewhere ignored", n + 50, T_SHORT);

        // R5: service write clears the counter only
        skip(49);
        bus_addr = 16'hFFFF; bus_wr = 1'b1;
        @(negedge clk); idle_bus();
        wait_pulse(n);
        check("R5 service write restart", n + 50, 160);

        // R6: service write collides with expiring tick
        skip(111);
        bus_addr = 16'hFFFF; bus_wr = 1'b1;
        @(negedge clk); idle_bus();
        check("R6 collision no request", int'(rst_req), 0);
        wait_pulse(n);
        check("R6 fresh period", n, T_SHORT);

        // R8: vector fetch clears prescaler
        skip(111);
        bus_addr = 16'hFFFF; bus_rd = 1'b1; vec_fetch = 1'b1;
        @(negedge clk); idle_bus();
        check("R8 fetch suppresses tick", int'(rst_req), 0);
        wait_pulse(n);
        check("R8 prescaler restarted", n, 1 << PB);

        // R9: disabled
        cfg_off = 1'b1;
        seen = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (rst_req) seen++;
        end
        check("R9 silent while off", seen, 0);
        cfg_off = 1'b0;
        wait_pulse(n);
        check("R9 full period after enable", n, T_SHORT);

        // R10: switch to short past the short limit
        cfg_short = 1'b0;
        skip(320);
        cfg_short = 1'b1;
        wait_pulse(n);
        check("R10 expire at next tick", n, 1 << PB);

        // R7: read mux
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            bus_addr = ($urandom % 4 == 0) ? 16'hFFFF : 16'($urandom);
            bus_rd   = 1'($urandom);
            vec_lo   = 8'($urandom);
            #1;
            check("R7 rd_data", int'(rd_data), exp_rd_data(bus_rd, bus_addr, vec_lo));
            check("R7 rd_hit", int'(rd_hit), int'(bus_rd && bus_addr == 16'hFFFF));
        end

        // Random mix checked against the model
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            bus_addr  = ($urandom % 8 == 0) ? 16'hFFFF : 16'($urandom);
            bus_wr    = ($urandom % 150 == 0);
            bus_rd    = 1'($urandom);
            vec_fetch = ($urandom % 200 == 0);
            vec_lo    = 8'($urandom);
            if ($urandom % 700 == 0) cfg_off = ~cfg_off;
            if ($urandom % 300 == 0) cfg_short = ~cfg_short;
            #1;
            check("R7 random read", int'(rd_data), exp_rd_data(bus_rd, bus_addr, vec_lo));
        end
        idle_bus();
        skip(2);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule